// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block produces the stop condition on an I2C bus for a single-master controller. It runs once a byte and its acknowledge clock have finished. The transfer logic around it holds SCL low at that point and signals this with an idle "transfer complete" input. Software then arms the sequencer with a stop-request pulse. The sequencer pulls SDA low under the low clock and releases SCL. It then releases SDA while SCL is high, which makes the low-to-high data edge that marks the stop.

Each phase moves on only when the real bus lines, read back through a synchronizer, show the level the sequencer asked for. At each such read-back a down-counting baud-rate generator is reloaded from a value set by software. The next line change waits for that counter to reach zero. Because the block waits for the read-back, a slave that stretches SCL or a line held low from outside simply delays the sequence. A stop-detected status bit, an interrupt flag and a write-collision flag report progress. The collision flag guards a transmit-buffer write port while a stop is pending or running.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, neither line is pulled low (scl_oe = sda_oe = 0), the status bits stop_pend, stop_seen, irq_flag and wcol_flag are 0, and tx_data is 0.
- R2: A stop_req pulse while xfer_done is 0 sets stop_pend and leaves both lines released for as long as xfer_done stays 0. At the first clock edge with xfer_done = 1, sda_oe and scl_oe both become 1.
- R3: SCL is never released while SDA is released during the sequence. SCL is released a fixed (brg_reload+1) + SYNC_STAGES + 1 clocks after the SDA line falls.
- R4: SDA is released a fixed (brg_reload+1) + SYNC_STAGES + 1 clocks after the SCL line is seen to rise, and only while SCL is released.
- R5: stop_seen rises SYNC_STAGES + 1 clocks after the SDA line rises, and only when both lines are released.
- R6: brg_reload+1 clocks after stop_seen rises, irq_flag becomes 1 and stop_pend becomes 0 in the same clock.
- R7: If a slave holds SCL low after it is released, the sequence waits. SDA stays low and stop_seen stays 0 until SCL actually goes high. The R4 interval then runs from that actual rise.
- R8: If SDA is held low from outside after it is released, stop_seen and irq_flag stay 0 and stop_pend stays 1. The stop completes after the line is freed.
- R9: A tx_we write while stop_pend is 1 sets wcol_flag on the next clock and leaves tx_data unchanged. A write while stop_pend is 0 loads tx_data and leaves wcol_flag at 0.
- R10: irq_flag and wcol_flag hold their value until their own clear pulse (irq_clr, wcol_clr). Either clear pulse has no effect on the other flag.
- R11: A xfer_start pulse clears stop_seen on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brg_reload | input | BRG_W | Baud-rate generator reload value; period is brg_reload+1 clocks |
| xfer_done | input | 1 | Byte transfer and acknowledge clock finished, SCL held low |
| xfer_start | input | 1 | Pulse: a new start or transfer begins, clears stop_seen |
| stop_req | input | 1 | Pulse: software sets the stop request |
| irq_clr | input | 1 | Pulse: software clears irq_flag |
| wcol_clr | input | 1 | Pulse: software clears wcol_flag |
| tx_we | input | 1 | Transmit-buffer write strobe |
| tx_wdata | input | DATA_W | Transmit-buffer write data |
| scl_in | input | 1 | SCL bus level read back |
| sda_in | input | 1 | SDA bus level read back |
| scl_oe | output | 1 | 1 pulls SCL low (open-drain) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| stop_pend | output | 1 | Stop request pending or running |
| stop_seen | output | 1 | Stop condition detected on the bus |
| irq_flag | output | 1 | Interrupt flag, set when the stop finishes |
| wcol_flag | output | 1 | Write-collision flag |
| tx_data | output | DATA_W | Transmit-buffer contents |

## Verification
A wrong phase state or a stale baud-rate count shows at the pins as a shifted edge between the bus lines. It can also show as SCL rising over a released SDA, and it appears within one baud period plus the synchronizer delay. The bench times every line edge and flag edge against the interval that the reload value and synchronizer depth predict. It does this across a sweep of reload values, and again with a stretched clock and with a data line held low. A request or write that is not recorded correctly shows up as an early drive of the lines, as a buffer change, or as a missing collision flag on the very next clock.

// File: rtl/i2cstop_pkg.sv
package i2cstop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SDA_LOW = 3'd1,
    ST_SCL_CNT = 3'd2,
    ST_SCL_REL = 3'd3,
    ST_SDA_CNT = 3'd4,
    ST_SDA_REL = 3'd5,
    ST_FIN_CNT = 3'd6
  } stop_state_t;

  function automatic logic pulls_scl(stop_state_t s);
    return (s == ST_SDA_LOW) || (s == ST_SCL_CNT);
  endfunction

  function automatic logic pulls_sda(stop_state_t s);
    return (s == ST_SDA_LOW) || (s == ST_SCL_CNT) ||
           (s == ST_SCL_REL) || (s == ST_SDA_CNT);
  endfunction
endpackage

// File: rtl/stop_line_sync.sv
module stop_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= line_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_s = sh[STAGES-1];
endmodule

// File: rtl/stop_brg.sv
module stop_brg #(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [BRG_W-1:0] reload,
  output logic             zero
);
  logic [BRG_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= reload;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import i2cstop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic xfer_done,
  input  logic scl_s,
  input  logic sda_s,
  input  logic brg_zero,
  output logic brg_load,
  output logic brg_run,
  output logic det_set,
  output logic seq_done,
  output logic scl_oe,
  output logic sda_oe
);
  stop_state_t st, st_n;

  always_comb begin
    st_n     = st;
    brg_load = 1'b0;
    brg_run  = 1'b0;
    det_set  = 1'b0;
    seq_done = 1'b0;
    case (st)
      ST_IDLE:    if (pend && xfer_done) st_n = ST_SDA_LOW;
      ST_SDA_LOW: if (!sda_s) begin
                    brg_load = 1'b1;
                    st_n     = ST_SCL_CNT;
                  end
      ST_SCL_CNT: begin
                    brg_run = 1'b1;
                    if (brg_zero) st_n = ST_SCL_REL;
                  end
      ST_SCL_REL: if (scl_s) begin
                    brg_load = 1'b1;
                    st_n     = ST_SDA_CNT;
                  end
      ST_SDA_CNT: begin
                    brg_run = 1'b1;
                    if (brg_zero) st_n = ST_SDA_REL;
                  end
      ST_SDA_REL: if (sda_s && scl_s) begin
                    brg_load = 1'b1;
                    det_set  = 1'b1;
                    st_n     = ST_FIN_CNT;
                  end
      ST_FIN_CNT: begin
                    brg_run = 1'b1;
                    if (brg_zero) begin
                      seq_done = 1'b1;
                      st_n     = ST_IDLE;
                    end
                  end
      default:    st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      st     <= st_n;
      scl_oe <= pulls_scl(st_n);
      sda_oe <= pulls_sda(st_n);
    end
  end
endmodule

// File: rtl/stop_regs.sv
module stop_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              xfer_start,
  input  logic              irq_clr,
  input  logic              wcol_clr,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              det_set,
  input  logic              seq_done,
  output logic              pend,
  output logic              seen,
  output logic              irq,
  output logic              wcol,
  output logic [DATA_W-1:0] tx_q
);
  logic collide;
  assign collide = tx_we && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      seen <= 1'b0;
      irq  <= 1'b0;
      wcol <= 1'b0;
      tx_q <= '0;
    end else begin
      if (seq_done)      pend <= 1'b0;
      else if (stop_req) pend <= 1'b1;

      if (det_set)         seen <= 1'b1;
      else if (xfer_start) seen <= 1'b0;

      if (seq_done)     irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;

      if (collide)       wcol <= 1'b1;
      else if (wcol_clr) wcol <= 1'b0;

      if (tx_we && !pend) tx_q <= tx_wdata;
    end
  end
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq #(
  parameter int BRG_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BRG_W-1:0]  brg_reload,
  input  logic              xfer_done,
  input  logic              xfer_start,
  input  logic              stop_req,
  input  logic              irq_clr,
  input  logic              wcol_clr,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              stop_pend,
  output logic              stop_seen,
  output logic              irq_flag,
  output logic              wcol_flag,
  output logic [DATA_W-1:0] tx_data
);
  logic scl_s, sda_s, brg_zero, brg_load, brg_run, det_set, seq_done;

  stop_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_in(scl_in), .line_s(scl_s));
  stop_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_in(sda_in), .line_s(sda_s));

  stop_brg #(.BRG_W(BRG_W)) u_brg (
    .clk(clk), .rst(rst), .load(brg_load), .run(brg_run),
    .reload(brg_reload), .zero(brg_zero));

  stop_fsm u_fsm (
    .clk(clk), .rst(rst), .pend(stop_pend), .xfer_done(xfer_done),
    .scl_s(scl_s), .sda_s(sda_s), .brg_zero(brg_zero),
    .brg_load(brg_load), .brg_run(brg_run), .det_set(det_set),
    .seq_done(seq_done), .scl_oe(scl_oe), .sda_oe(sda_oe));

  stop_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .stop_req(stop_req), .xfer_start(xfer_start),
    .irq_clr(irq_clr), .wcol_clr(wcol_clr), .tx_we(tx_we),
    .tx_wdata(tx_wdata), .det_set(det_set), .seq_done(seq_done),
    .pend(stop_pend), .seen(stop_seen), .irq(irq_flag),
    .wcol(wcol_flag), .tx_q(tx_data));
endmodule

// File: rtl/i2c_stop_seq_chk.sv
module i2c_stop_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_done,
  input logic              irq_clr,
  input logic              tx_we,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              stop_pend,
  input logic              stop_seen,
  input logic              irq_flag,
  input logic              wcol_flag,
  input logic [DATA_W-1:0] tx_data
);
  // R2: data line only starts being pulled once the transfer is complete
  assert_drive_after_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(xfer_done));

  // R3: clock released only over a low data line
  assert_scl_over_low_sda_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> sda_oe);

  // R4: data released only while clock is released
  assert_sda_rise_scl_high_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_oe);

  // R5: detection only with both lines released
  assert_seen_lines_free_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_seen) |-> (!sda_oe && !scl_oe));

  // R6: interrupt raised together with request clear
  assert_irq_clears_pend_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> (!stop_pend && $past(stop_pend)));

  // R9: write during a pending stop collides and leaves the buffer alone
  assert_collision_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_we && stop_pend) |=> (wcol_flag && $stable(tx_data)));

  // R10: interrupt flag persists without its clear pulse
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind i2c_stop_seq i2c_stop_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .xfer_done(xfer_done), .irq_clr(irq_clr),
  .tx_we(tx_we), .scl_oe(scl_oe), .sda_oe(sda_oe), .stop_pend(stop_pend),
  .stop_seen(stop_seen), .irq_flag(irq_flag), .wcol_flag(wcol_flag),
  .tx_data(tx_data));

// File: tb/i2c_stop_seq_test.sv
module i2c_stop_seq_test;
  localparam int BRG_W = 8;
  localparam int DATA_W = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BRG_W-1:0] brg_reload = '0;
  logic xfer_done = 1'b0, xfer_start = 1'b0, stop_req = 1'b0;
  logic irq_clr = 1'b0, wcol_clr = 1'b0, tx_we = 1'b0;
  logic [DATA_W-1:0] tx_wdata = '0;
  logic scl_hold = 1'b0, sda_hold = 1'b0;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe, stop_pend, stop_seen, irq_flag, wcol_flag;
  logic [DATA_W-1:0] tx_data;

  assign scl_line = !scl_oe && !scl_hold;
  assign sda_line = !sda_oe && !sda_hold;

  always #10 clk = ~clk;

  i2c_stop_seq #(.BRG_W(BRG_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .brg_reload(brg_reload), .xfer_done(xfer_done),
    .xfer_start(xfer_start), .stop_req(stop_req), .irq_clr(irq_clr),
    .wcol_clr(wcol_clr), .tx_we(tx_we), .tx_wdata(tx_wdata),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .stop_pend(stop_pend), .stop_seen(stop_seen), .irq_flag(irq_flag),
    .wcol_flag(wcol_flag), .tx_data(tx_data));

  int total = 0, fails = 0, cyc = 0;
  int t_sda_fall, t_scl_rise, t_sda_rise, t_seen, t_irq, t_pend_fall;
  logic p_sda = 1'b1, p_scl = 1'b1, p_seen = 1'b0, p_irq = 1'b0, p_pend = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (p_sda && !sda_line && t_sda_fall < 0) t_sda_fall = cyc;
    if (!p_scl && scl_line && t_scl_rise < 0) t_scl_rise = cyc;
    if (!p_sda && sda_line && t_sda_rise < 0) t_sda_rise = cyc;
    if (!p_seen && stop_seen && t_seen < 0) t_seen = cyc;
    if (!p_irq && irq_flag && t_irq < 0) t_irq = cyc;
    if (p_pend && !stop_pend && t_pend_fall < 0) t_pend_fall = cyc;
    p_sda = sda_line; p_scl = scl_line; p_seen = stop_seen;
    p_irq = irq_flag; p_pend = stop_pend;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_marks();
    @(posedge clk);
    t_sda_fall = -1; t_scl_rise = -1; t_sda_rise = -1;
    t_seen = -1; t_irq = -1; t_pend_fall = -1;
  endtask

  task automatic pulse_req(); @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0; endtask
  task automatic pulse_start(); @(negedge clk); xfer_start = 1; @(negedge clk); xfer_start = 0; endtask
  task automatic pulse_iclr(); @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; endtask
  task automatic pulse_wclr(); @(negedge clk); wcol_clr = 1; @(negedge clk); wcol_clr = 0; endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000 && !irq_flag; i++) @(negedge clk);
  endtask

  // full stop with reload r; checks R3..R6 intervals
  task automatic run_stop(input int r);
    @(negedge clk); brg_reload = BRG_W'(r); xfer_done = 1;
    pulse_iclr();
    pulse_start();
    clear_marks();
    pulse_req();
    wait_irq();
    @(negedge clk);
    chk(t_scl_rise - t_sda_fall == r + SYNC + 2, "R3 sda-low to scl-rise",
        t_scl_rise - t_sda_fall, r + SYNC + 2);
    chk(t_sda_rise - t_scl_rise == r + SYNC + 2, "R4 scl-rise to sda-rise",
        t_sda_rise - t_scl_rise, r + SYNC + 2);
    chk(t_seen - t_sda_rise == SYNC + 1, "R5 sda-rise to stop_seen",
        t_seen - t_sda_rise, SYNC + 1);
    chk(t_irq - t_seen == r + 1, "R6 stop_seen to irq", t_irq - t_seen, r + 1);
    chk(t_pend_fall == t_irq && !stop_pend, "R6 pend clears with irq",
        t_pend_fall, t_irq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk({stop_pend, stop_seen, irq_flag, wcol_flag} == 4'b0, "R1 status",
        {stop_pend, stop_seen, irq_flag, wcol_flag}, 0);
    chk(tx_data == 0, "R1 tx_data", tx_data, 0);

    // R9 idle write loads buffer
    @(negedge clk); tx_we = 1; tx_wdata = 8'hA5; @(negedge clk); tx_we = 0;
    chk(tx_data == 8'hA5, "R9 idle write", tx_data, 8'hA5);
    chk(!wcol_flag, "R9 no collision idle", wcol_flag, 0);

    // R2 pending request
    xfer_done = 0; brg_reload = 8'd2;
    clear_marks();
    pulse_req();
    repeat (10) @(negedge clk);
    chk(stop_pend && !sda_oe && !scl_oe, "R2 held pending",
        {stop_pend, sda_oe, scl_oe}, 3'b100);
    // R9 collision while pending
    tx_we = 1; tx_wdata = 8'h3C; @(negedge clk); tx_we = 0;
    chk(wcol_flag, "R9 collision flag", wcol_flag, 1);
    chk(tx_data == 8'hA5, "R9 buffer unchanged", tx_data, 8'hA5);
    xfer_done = 1;
    @(negedge clk);
    chk(sda_oe && scl_oe, "R2 drive after done", {sda_oe, scl_oe}, 3);
    wait_irq();
    chk(irq_flag, "R2 completes", irq_flag, 1);

    // R10 stickiness and independent clears
    repeat (20) @(negedge clk);
    chk(irq_flag && wcol_flag, "R10 flags persist", {irq_flag, wcol_flag}, 3);
    pulse_wclr();
    chk(irq_flag && !wcol_flag, "R10 wcol clear only", {irq_flag, wcol_flag}, 2);
    pulse_iclr();
    chk(!irq_flag && !wcol_flag, "R10 irq clear", {irq_flag, wcol_flag}, 0);

    // R11 stop_seen cleared by new transfer
    chk(stop_seen, "R11 seen set before clear", stop_seen, 1);
    @(negedge clk); xfer_start = 1; @(negedge clk); xfer_start = 0;
    chk(!stop_seen, "R11 seen cleared", stop_seen, 0);

    // sweep of reload values
    for (int r = 0; r < 16; r++) run_stop(r);
    run_stop(40);

    // R7 clock stretching
    @(negedge clk); brg_reload = 8'd3;
    pulse_iclr(); pulse_start();
    scl_hold = 1;
    clear_marks();
    pulse_req();
    for (int i = 0; i < 200 && scl_oe !== 1'b0; i++) @(negedge clk);
    repeat (15) @(negedge clk);
    chk(!sda_line && !stop_seen && t_scl_rise < 0, "R7 waits while stretched",
        {sda_line, stop_seen}, 0);
    scl_hold = 0;
    wait_irq();
    @(negedge clk);
    chk(t_sda_rise - t_scl_rise == 3 + SYNC + 2, "R7 interval from real rise",
        t_sda_rise - t_scl_rise, 3 + SYNC + 2);

    // R8 data held low externally
    @(negedge clk); brg_reload = 8'd1;
    pulse_iclr(); pulse_start();
    sda_hold = 1;
    pulse_req();
    repeat (60) @(negedge clk);
    chk(!stop_seen && !irq_flag && stop_pend, "R8 stalled",
        {stop_seen, irq_flag, stop_pend}, 3'b001);
    sda_hold = 0;
    wait_irq();
    chk(irq_flag && stop_seen, "R8 completes after release",
        {irq_flag, stop_seen}, 3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule